// File: doc/BRIEF.md
# Scanline-Rate Interrupt Timer

This block raises an interrupt after a programmed number of prescaled CPU-clock periods. A divider counts CPU cycles in groups of 113, which is close to the length of one video line. At the end of each group an 8-bit up-counter advances by one. When the counter steps past its all-ones value, it takes its start value again from a reload register and sets an active-high interrupt request. The request stays set until software acknowledges it.

Software programs the reload value with two 4-bit writes. A control write then arms the timer. Arming copies the reload value into the counter and restarts the divider. The same control write clears any pending request. If the control write leaves the run bit clear, counting stops. The interrupt fires exactly (256 − reload) × 113 cycles after the arming write. A reload of 0xFF therefore gives one line, and a reload of 0x00 gives 256 lines.

Top module: `scan_irq_timer`

## Requirements
- R1: A write to address 0xF000 sets reload bits [3:0] from data bits [3:0]. Data bits [7:4] of that write are ignored, and reload bits [7:4] keep their value.
- R2: A write to address 0xF004 sets reload bits [7:4] from data bits [3:0]. Reload bits [3:0] keep their value.
- R3: A write to address 0xF008 stores data bits [1:0] as the control value, where bit 1 is the run bit. If data bit 1 is 1, the same write loads the counter from the reload register, clears the divider to 0 and starts counting.
- R4: Every write to 0xF008 drives `irq` low on the cycle after the write edge, whatever the data.
- R5: While the run bit is 1, the divider produces one counter step every 113 clock cycles.
- R6: On a step, a counter below 0xFF increments by one. A counter at 0xFF reloads from the reload register and sets `irq`. For reload value L, `irq` first reads 1 exactly (256 − L) × 113 cycles after the arming write edge.
- R7: Once set, `irq` stays 1 through any further counter overflows until the next write to 0xF008.
- R8: After a write to 0xF008 with data bit 1 equal to 0 (control values 0x00 or 0x01), the counter stops and `irq` stays 0.
- R9: Reload writes made while counting do not change the pass already in progress.
- R10: Synchronous reset clears the reload register, counter, divider, control value and `irq`. After reset with no writes, `irq` stays 0.
- R11: Writes to any address other than 0xF000, 0xF004 and 0xF008 have no effect on the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; one divider count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Active-high interrupt request, held until acknowledged |

## Verification
The counter and divider are not visible at the ports. Their state therefore shows up only in the cycle on which `irq` rises.

A divider that is off by one in its terminal count, or that is not cleared when the timer is armed, moves that edge by a number of cycles proportional to the number of steps. With a reload of 0x00, one error per step shifts the edge by 256 cycles. A wrong reload nibble or a wrongly decoded address shifts the edge by whole multiples of 113 cycles.

The bench therefore measures the exact arrival cycle for a sweep of reload values, each against (256 − L) × 113. A lost or sticky pending flag shows on the cycle right after a control write.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

    localparam int unsigned ADDR_W       = 16;
    localparam int unsigned DATA_W_DEF   = 8;
    localparam int unsigned CNT_W_DEF    = 8;
    localparam int unsigned PRESCALE_DEF = 113;

    // Register decode addresses (software-visible map)
    localparam logic [ADDR_W-1:0] ADR_RELOAD_LO = 16'hF000;
    localparam logic [ADDR_W-1:0] ADR_RELOAD_HI = 16'hF004;
    localparam logic [ADDR_W-1:0] ADR_CONTROL   = 16'hF008;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_RELOAD_LO,
        REQ_RELOAD_HI,
        REQ_CONTROL
    } req_e;

    // Control value: run enables counting, rearm is folded into run on overflow
    typedef struct packed {
        logic run;
        logic rearm;
    } ctrl_t;

    function automatic req_e decode_req(input logic en, input logic [ADDR_W-1:0] a);
        req_e r;
        r = REQ_NONE;
        if (en) begin
            if (a == ADR_RELOAD_LO)      r = REQ_RELOAD_LO;
            else if (a == ADR_RELOAD_HI) r = REQ_RELOAD_HI;
            else if (a == ADR_CONTROL)   r = REQ_CONTROL;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_reload_latch.sv
module irq_reload_latch
    import scan_irq_pkg::*;
#(
    parameter int unsigned W = CNT_W_DEF,
    localparam int unsigned H = W / 2
) (
    input  logic         clk,
    input  logic         rst,
    input  req_e         req,
    input  logic [H-1:0] nib,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else begin
            case (req)
                REQ_RELOAD_LO: value[H-1:0] <= nib;
                REQ_RELOAD_HI: value[W-1:H] <= nib[W-H-1:0];
                default: ;
            endcase
        end
    end

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        req == REQ_RELOAD_LO |=> value[W-1:H] == $past(value[W-1:H])) else $error("lo write touched hi"); // R1
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        req == REQ_RELOAD_HI |=> value[H-1:0] == $past(value[H-1:0])) else $error("hi write touched lo"); // R2
    AST_RELOAD_STILL: assert property (@(posedge clk) disable iff (rst)
        (req != REQ_RELOAD_LO && req != REQ_RELOAD_HI) |=> $stable(value)) else $error("reload changed"); // R11

endmodule

// File: rtl/irq_prescaler.sv
module irq_prescaler
    import scan_irq_pkg::*;
#(
    parameter int unsigned PRESCALE = PRESCALE_DEF,
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);

    logic [PW-1:0] pre;
    logic          at_end;

    assign at_end = (pre == PW'(PRESCALE - 1));
    assign tick   = run && !clr && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre <= '0;
        end else if (run) begin
            pre <= at_end ? '0 : pre + PW'(1);
        end
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
        pre < PW'(PRESCALE)) else $error("divider out of range"); // R5
    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> pre == '0) else $error("divider not cleared on arm"); // R3
    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(pre)) else $error("divider moved while stopped"); // R8

endmodule

// File: rtl/irq_up_counter.sv
module irq_up_counter
    import scan_irq_pkg::*;
#(
    parameter int unsigned W = CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    logic at_top;

    assign at_top = (cnt == '1);
    assign wrap   = tick && !load && at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load || wrap) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= cnt + W'(1);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt != '1) |=> cnt == $past(cnt) + W'(1)) else $error("bad step"); // R6
    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt == '1) |=> cnt == $past(load_val)) else $error("bad reload"); // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt)) else $error("count moved without step"); // R8

endmodule

// File: rtl/scan_irq_timer.sv
module scan_irq_timer
    import scan_irq_pkg::*;
#(
    parameter int unsigned DATA_W   = DATA_W_DEF,
    parameter int unsigned CNT_W    = CNT_W_DEF,
    parameter int unsigned PRESCALE = PRESCALE_DEF,
    localparam int unsigned NIB_W   = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq
);

    req_e             req;
    ctrl_t            ctrl;
    logic             arm;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             unused_data_hi;

    assign req            = decode_req(wr_en, wr_addr);
    assign arm            = (req == REQ_CONTROL) && wr_data[1];
    assign unused_data_hi = ^wr_data[DATA_W-1:NIB_W];

    irq_reload_latch #(.W(CNT_W)) latch_i (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .nib   (wr_data[NIB_W-1:0]),
        .value (reload)
    );

    irq_prescaler #(.PRESCALE(PRESCALE)) presc_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (arm),
        .run  (ctrl.run),
        .tick (tick)
    );

    irq_up_counter #(.W(CNT_W)) count_i (
        .clk      (clk),
        .rst      (rst),
        .load     (arm),
        .load_val (reload),
        .tick     (tick),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            irq  <= 1'b0;
        end else if (req == REQ_CONTROL) begin
            ctrl <= ctrl_t'(wr_data[1:0]);
            irq  <= 1'b0;
        end else if (wrap) begin
            ctrl.run <= ctrl.run | ctrl.rearm;
            irq      <= 1'b1;
        end
    end

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        req == REQ_CONTROL |=> !irq) else $error("irq not cleared by control write"); // R4
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && req != REQ_CONTROL) |=> irq) else $error("irq dropped without ack"); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!irq && !wrap) |=> !irq) else $error("irq rose without overflow"); // R6
    AST_ARM_LOAD: assert property (@(posedge clk) disable iff (rst)
        arm |=> cnt == $past(reload)) else $error("arm did not load counter"); // R3
    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !arm) |=> !tick) else $error("step while stopped"); // R8

endmodule

// File: tb/scan_irq_timer_tb.sv
module scan_irq_timer_tb_top;

    localparam int PRE = 113;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        irq;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scan_irq_timer dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq     (irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Nibble writes carry junk in data[7:4] (R1, R2), then arm with run bit set
    task automatic arm(input logic [7:0] l, output int t0);
        wr(16'hF000, {4'hA, l[3:0]});
        wr(16'hF004, {4'h5, l[7:4]});
        wr(16'hF008, 8'h02);
        t0 = cyc;
    endtask

    task automatic wait_irq(input int t0, input int lim, output int d);
        while (!irq && (cyc - t0) < lim) @(negedge clk);
        d = cyc - t0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int t0;
        int d;
        logic [7:0] sweep [6];
        sweep = '{8'hFE, 8'hFF, 8'hF0, 8'h80, 8'h00, 8'h0F};

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R10 reset", irq, 0);
        idle(500);
        check(irq == 1'b0, "R10 idle after reset", irq, 0);

        // Sweep of reload values: exact arrival cycle (R1 R2 R3 R5 R6)
        foreach (sweep[i]) begin
            arm(sweep[i], t0);
            wait_irq(t0, 30000, d);
            check(d == (256 - int'(sweep[i])) * PRE, "R6 arrival", d, (256 - int'(sweep[i])) * PRE);
        end

        // R7: pending held across further overflows (0x0F pass is 241 lines, use short one)
        arm(8'hFF, t0);
        wait_irq(t0, 1000, d);
        check(d == PRE, "R5 single line", d, PRE);
        idle(4 * PRE + 7);
        check(irq == 1'b1, "R7 held", irq, 1);

        // R4: acknowledge with control 0x00 clears next cycle
        wr(16'hF008, 8'h00);
        @(negedge clk);
        check(irq == 1'b0, "R4 ack clear", irq, 0);

        // R8: disable mid-count, then bit0-only control
        arm(8'hFE, t0);
        idle(100);
        wr(16'hF008, 8'h00);
        idle(600);
        check(irq == 1'b0, "R8 stopped", irq, 0);
        wr(16'hF008, 8'h01);
        idle(600);
        check(irq == 1'b0, "R8 bit0 only", irq, 0);

        // R9: reload rewritten during a pass
        arm(8'hFE, t0);
        idle(40);
        wr(16'hF000, 8'h00);
        wr(16'hF004, 8'h00);
        wait_irq(t0, 30000, d);
        check(d == 2 * PRE, "R9 pass unchanged", d, 2 * PRE);

        // R11: stray writes near the register addresses are ignored
        arm(8'hFE, t0);
        idle(10);
        wr(16'hF00C, 8'h02);
        wr(16'hF018, 8'h02);
        wr(16'hE008, 8'h00);
        wr(16'h7008, 8'h00);
        wait_irq(t0, 30000, d);
        check(d == 2 * PRE, "R11 stray writes", d, 2 * PRE);
        wr(16'hF009, 8'h00);
        @(negedge clk);
        check(irq == 1'b1, "R11 stray ack ignored", irq, 1);

        // R4 + R3: ack with run bit rearms from current reload (0xFE here)
        wr(16'hF008, 8'h02);
        t0 = cyc;
        @(negedge clk);
        check(irq == 1'b0, "R4 rearm clear", irq, 0);
        wait_irq(t0, 30000, d);
        check(d == 2 * PRE, "R3 rearm timing", d, 2 * PRE);

        // R10: reset mid-pass clears everything
        arm(8'hFF, t0);
        idle(50);
        @(negedge clk) rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(400);
        check(irq == 1'b0, "R10 reset stops", irq, 0);
        wr(16'hF008, 8'h02);
        t0 = cyc;
        wait_irq(t0, 30000, d);
        check(d == 256 * PRE, "R10 reload cleared", d, 256 * PRE);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule